// File: doc/BRIEF.md
# Single Result Bus Arbiter

This block shares one result broadcast bus among several functional units of an out-of-order core. A unit that has finished executing raises its request and presents the tag of the station that produced the result, the result value, and the issue sequence number of the instruction. In every cycle the arbiter grants exactly one waiting unit. In the next cycle it drives that unit's tag and value pair onto the bus. Every reservation station and every register status entry sees that pair in the same cycle.

When several results are ready together, the instruction that issued first gets the bus. Sequence numbers wrap around, so they are compared with modular arithmetic. A unit that loses keeps its request, tag, value and sequence number steady and tries again in the next cycle. Each lost round delays its broadcast by one cycle. The one-hot grant is the only back-pressure the units receive. Tag zero is reserved and means that nothing is broadcast. The bus carries tag zero in every idle cycle, so requesters must use nonzero tags.

Top module: `rbus_arbiter`

## Requirements
- R1: While reset is held (rstN low, active low), busValid, busTag and busValue are all zero.
- R2: The grant is combinational and has at most one bit set. A bit is set only for a requester whose reqValid is high. At least one bit is set in any cycle in which any reqValid is high.
- R3: If requester k is granted in a cycle, then after the following clock edge busValid is 1, busTag equals k's tag and busValue equals k's value. A request seen in cycle c is therefore broadcast in cycle c+1.
- R4: If no requester is valid in a cycle, then after the following clock edge busValid is 0, busTag is the reserved code 0 and busValue is 0.
- R5: Among the valid requesters, the one with the oldest sequence number is granted. Sequence a is older than sequence b when (b - a) mod 2^SEQ_W lies between 1 and 2^(SEQ_W-1) - 1. This assumes that all live sequence numbers lie within half the range.
- R6: The age comparison works across wraparound. With SEQ_W = 6, sequence 62 is older than 63, and 63 is older than 0 and 1.
- R7: If two valid requesters carry the same sequence number, the one with the lower index wins.
- R8: A requester that is not granted gets no broadcast in that cycle. It keeps its request and is granted in a later cycle, and each lost round adds exactly one cycle before its broadcast.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | NUM_REQ | Per-unit result ready flag |
| reqTag | input | NUM_REQ x TAG_W | Per-unit producing station tag (nonzero) |
| reqValue | input | NUM_REQ x DATA_W | Per-unit result value |
| reqSeq | input | NUM_REQ x SEQ_W | Per-unit issue sequence number |
| grant | output | NUM_REQ | One-hot grant, same cycle as the request |
| busValid | output | 1 | Bus carries a result this cycle |
| busTag | output | TAG_W | Broadcast tag, 0 when idle |
| busValue | output | DATA_W | Broadcast value, 0 when idle |

## Verification
Two things can fall in the same cycle. Age selection among simultaneous requests, with wrapped or equal sequence numbers, can coincide with a loser's retry. Likewise, a new arrival can land in the same cycle that an older, held result is re-presented. Directed cases set up both situations: wrapped sequences across all four units, an equal-sequence tie, and a two-way loss followed by the retry. Random arrivals that keep several results pending at once add more of them. Each grant is judged against an oldest-first reference that the bench computes from distances behind its own issue counter. The bus one cycle later is judged against the tag and value that the bench itself holds for the expected winner.

// File: rtl/rbus_pkg.sv
package rbus_pkg;
  // strobes from the grant control to the bus datapath
  typedef struct packed {
    logic capture; // load the granted pair onto the bus
    logic idle;    // drive the no-broadcast code
  } busStrobe_t;
endpackage

// File: rtl/rbus_grant_ctrl.sv
module rbus_grant_ctrl
  import rbus_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int SEQ_W   = 6
) (
  input  logic [NUM_REQ-1:0]            reqValid,
  input  logic [NUM_REQ-1:0][SEQ_W-1:0] reqSeq,
  output logic [NUM_REQ-1:0]            grant,
  output busStrobe_t                    strobe
);
  localparam logic [SEQ_W-1:0] HALF_RANGE = SEQ_W'(1) << (SEQ_W - 1);

  // a issued before b under modular ordering
  function automatic logic seqOlder(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    logic [SEQ_W-1:0] gap;
    gap = b - a;
    return (gap != '0) && (gap < HALF_RANGE);
  endfunction

  // beats[i][j]: requester i does not lose to requester j
  logic [NUM_REQ-1:0][NUM_REQ-1:0] beats;
  logic [NUM_REQ-1:0] winVec;

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_row
    for (genvar j = 0; j < NUM_REQ; j++) begin : g_col
      if (i == j) begin : g_self
        assign beats[i][j] = 1'b1;
      end else if (i < j) begin : g_tieWin
        assign beats[i][j] = !reqValid[j] || seqOlder(reqSeq[i], reqSeq[j])
                             || (reqSeq[i] == reqSeq[j]);
      end else begin : g_tieLose
        assign beats[i][j] = !reqValid[j] || seqOlder(reqSeq[i], reqSeq[j]);
      end
    end
    assign winVec[i] = reqValid[i] && (&beats[i]);
  end

  // keep the grant one-hot even for sequence sets outside the window
  always_comb begin
    logic found;
    grant = '0;
    found = 1'b0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (!found && winVec[i]) begin
        grant[i] = 1'b1;
        found = 1'b1;
      end
    end
    for (int i = 0; i < NUM_REQ; i++) begin
      if (!found && reqValid[i]) begin
        grant[i] = 1'b1;
        found = 1'b1;
      end
    end
  end

  assign strobe.capture = |reqValid;
  assign strobe.idle    = ~|reqValid;
endmodule

// File: rtl/rbus_datapath.sv
module rbus_datapath
  import rbus_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int TAG_W   = 4,
  parameter int DATA_W  = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  busStrobe_t                      strobe,
  input  logic [NUM_REQ-1:0]              grant,
  input  logic [NUM_REQ-1:0][TAG_W-1:0]   reqTag,
  input  logic [NUM_REQ-1:0][DATA_W-1:0]  reqValue,
  output logic                            busValid,
  output logic [TAG_W-1:0]                busTag,
  output logic [DATA_W-1:0]               busValue
);
  logic [TAG_W-1:0]  selTag;
  logic [DATA_W-1:0] selValue;

  // one-hot AND-OR select
  always_comb begin
    selTag   = '0;
    selValue = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      selTag   = selTag   | ({TAG_W{grant[i]}}  & reqTag[i]);
      selValue = selValue | ({DATA_W{grant[i]}} & reqValue[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busValid <= 1'b0;
      busTag   <= '0;
      busValue <= '0;
    end else if (strobe.capture) begin
      busValid <= 1'b1;
      busTag   <= selTag;
      busValue <= selValue;
    end else begin
      busValid <= 1'b0;
      busTag   <= '0;
      busValue <= '0;
    end
  end
endmodule

// File: rtl/rbus_arbiter.sv
module rbus_arbiter
  import rbus_pkg::*;
#(
  parameter int NUM_REQ = 4,
  parameter int TAG_W   = 4,
  parameter int DATA_W  = 16,
  parameter int SEQ_W   = 6
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [NUM_REQ-1:0]              reqValid,
  input  logic [NUM_REQ-1:0][TAG_W-1:0]   reqTag,
  input  logic [NUM_REQ-1:0][DATA_W-1:0]  reqValue,
  input  logic [NUM_REQ-1:0][SEQ_W-1:0]   reqSeq,
  output logic [NUM_REQ-1:0]              grant,
  output logic                            busValid,
  output logic [TAG_W-1:0]                busTag,
  output logic [DATA_W-1:0]               busValue
);
  busStrobe_t strobe;

  rbus_grant_ctrl #(.NUM_REQ(NUM_REQ), .SEQ_W(SEQ_W)) ctrl (
    .reqValid(reqValid),
    .reqSeq  (reqSeq),
    .grant   (grant),
    .strobe  (strobe)
  );

  rbus_datapath #(.NUM_REQ(NUM_REQ), .TAG_W(TAG_W), .DATA_W(DATA_W)) dpath (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .grant   (grant),
    .reqTag  (reqTag),
    .reqValue(reqValue),
    .busValid(busValid),
    .busTag  (busTag),
    .busValue(busValue)
  );
endmodule

// File: rtl/rbus_arbiter_chk.sv
module rbus_arbiter_chk #(
  parameter int NUM_REQ = 4,
  parameter int TAG_W   = 4,
  parameter int DATA_W  = 16,
  parameter int SEQ_W   = 6
) (
  input logic                            clk,
  input logic                            rstN,
  input logic [NUM_REQ-1:0]              reqValid,
  input logic [NUM_REQ-1:0][TAG_W-1:0]   reqTag,
  input logic [NUM_REQ-1:0][DATA_W-1:0]  reqValue,
  input logic [NUM_REQ-1:0][SEQ_W-1:0]   reqSeq,
  input logic [NUM_REQ-1:0]              grant,
  input logic                            busValid,
  input logic [TAG_W-1:0]                busTag,
  input logic [DATA_W-1:0]               busValue
);
  localparam int SEQ_MOD = 1 << SEQ_W;

  function automatic bit chkOlder(input logic [SEQ_W-1:0] a, input logic [SEQ_W-1:0] b);
    int d;
    d = (int'(b) - int'(a) + SEQ_MOD) % SEQ_MOD;
    return (d >= 1) && (d < SEQ_MOD / 2);
  endfunction

  logic [TAG_W-1:0]  gTag;
  logic [DATA_W-1:0] gValue;
  always_comb begin
    gTag   = '0;
    gValue = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (grant[i]) begin
        gTag   = reqTag[i];
        gValue = reqValue[i];
      end
    end
  end

  assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant)) else $error("grant not one-hot");

  assert_grant_valid_R2: assert property (@(posedge clk) disable iff (!rstN)
    (grant & ~reqValid) == '0) else $error("grant to idle requester");

  assert_grant_live_R2: assert property (@(posedge clk) disable iff (!rstN)
    (|reqValid) |-> (|grant)) else $error("request left ungranted");

  assert_bus_load_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|grant) |=> (busValid && busTag == $past(gTag) && busValue == $past(gValue)))
    else $error("bus does not carry granted pair");

  assert_bus_idle_R4: assert property (@(posedge clk) disable iff (!rstN)
    !(|reqValid) |=> (!busValid && busTag == '0 && busValue == '0))
    else $error("idle bus not cleared");

  for (genvar i = 0; i < NUM_REQ; i++) begin : g_ci
    for (genvar j = 0; j < NUM_REQ; j++) begin : g_cj
      if (i != j) begin : g_pair
        assert_age_order_R5: assert property (@(posedge clk) disable iff (!rstN)
          (grant[i] && reqValid[j]) |-> !chkOlder(reqSeq[j], reqSeq[i]))
          else $error("younger requester granted");
      end
      if (j < i) begin : g_tie
        assert_tie_low_R7: assert property (@(posedge clk) disable iff (!rstN)
          (grant[i] && reqValid[j]) |-> (reqSeq[j] != reqSeq[i]))
          else $error("tie not resolved to lower index");
      end
    end
  end
endmodule

bind rbus_arbiter rbus_arbiter_chk #(
  .NUM_REQ(NUM_REQ), .TAG_W(TAG_W), .DATA_W(DATA_W), .SEQ_W(SEQ_W)
) chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqTag(reqTag),
  .reqValue(reqValue), .reqSeq(reqSeq), .grant(grant),
  .busValid(busValid), .busTag(busTag), .busValue(busValue)
);

// File: tb/rbus_arbiter_test.sv
`timescale 1ns/1ps
module rbus_arbiter_test;
  localparam int N = 4, TW = 4, DW = 16, SW = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #2.5 clk = ~clk;

  logic [N-1:0]          reqValid;
  logic [N-1:0][TW-1:0]  reqTag;
  logic [N-1:0][DW-1:0]  reqValue;
  logic [N-1:0][SW-1:0]  reqSeq;
  logic [N-1:0]          grant;
  logic                  busValid;
  logic [TW-1:0]         busTag;
  logic [DW-1:0]         busValue;

  rbus_arbiter #(.NUM_REQ(N), .TAG_W(TW), .DATA_W(DW), .SEQ_W(SW)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqTag(reqTag),
    .reqValue(reqValue), .reqSeq(reqSeq), .grant(grant),
    .busValid(busValid), .busTag(busTag), .busValue(busValue)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  int lastWin = -1;

  // bench-side model of the requesting units
  bit            pv[N];
  logic [TW-1:0] pt[N];
  logic [DW-1:0] pd[N];
  logic [SW-1:0] ps[N];
  logic [SW-1:0] nextSeq = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // oldest = farthest behind the bench issue counter; ties keep lower index
  function automatic int expWinner();
    int best = -1, bestDist = -1;
    for (int i = 0; i < N; i++) begin
      if (pv[i]) begin
        logic [SW-1:0] d;
        d = nextSeq - ps[i];
        if (int'(d) > bestDist) begin
          best = i;
          bestDist = int'(d);
        end
      end
    end
    return best;
  endfunction

  task automatic addReq(input int i, input logic [TW-1:0] tag, input logic [DW-1:0] val);
    pv[i] = 1'b1; pt[i] = tag; pd[i] = val; ps[i] = nextSeq;
    nextSeq = nextSeq + 1'b1;
  endtask

  task automatic step(input string rq);
    int w;
    logic [N-1:0] expGrant;
    logic eV;
    logic [TW-1:0] eT;
    logic [DW-1:0] eD;
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      reqValid[i] = pv[i]; reqTag[i] = pt[i]; reqValue[i] = pd[i]; reqSeq[i] = ps[i];
    end
    #1;
    w = expWinner();
    expGrant = (w < 0) ? '0 : N'(1) << w;
    check(grant == expGrant, {"R2 ", rq}, "grant", 32'(grant), 32'(expGrant));
    eV = (w >= 0);
    eT = (w >= 0) ? pt[w] : '0;
    eD = (w >= 0) ? pd[w] : '0;
    @(posedge clk);
    #1;
    if (eV) begin
      check(busValid == 1'b1 && busTag == eT && busValue == eD, "R3",
            "bus pair", {12'h0, busValid, 3'h0, busTag, busValue}, {12'h0, eV, 3'h0, eT, eD});
      pv[w] = 1'b0;
    end else begin
      check(busValid == 1'b0 && busTag == '0 && busValue == '0, "R4",
            "idle bus", {12'h0, busValid, 3'h0, busTag, busValue}, 32'h0);
    end
    lastWin = w;
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    for (int i = 0; i < N; i++) begin
      pv[i] = 0; pt[i] = '0; pd[i] = '0; ps[i] = '0;
    end
    reqValid = '0; reqTag = '0; reqValue = '0; reqSeq = '0;

    // R1: reset state
    repeat (3) @(posedge clk);
    #1;
    check(busValid == 0 && busTag == '0 && busValue == '0, "R1", "reset bus",
          {12'h0, busValid, 3'h0, busTag, busValue}, 32'h0);
    @(negedge clk);
    rstN = 1'b1;

    // R4: idle cycle
    step("R4");

    // R8: two finish together, the younger loses one round
    addReq(1, 4'h3, 16'hAAAA);
    addReq(0, 4'h5, 16'h5555);
    step("R8");
    check(lastWin == 1, "R8", "first winner", 32'(lastWin), 32'd1);
    step("R8");
    check(lastWin == 0, "R8", "loser after one lost round", 32'(lastWin), 32'd0);

    // R6: wrapped sequences, oldest sits at the highest index
    nextSeq = 6'd62;
    addReq(3, 4'h9, 16'h0062);
    addReq(0, 4'h1, 16'h0063);
    addReq(1, 4'h2, 16'h0000);
    addReq(2, 4'h4, 16'h0001);
    step("R6");
    check(lastWin == 3, "R6", "seq 62 first", 32'(lastWin), 32'd3);
    step("R6");
    check(lastWin == 0, "R6", "seq 63 second", 32'(lastWin), 32'd0);
    step("R6");
    step("R6");

    // R7: equal sequence numbers
    pv[2] = 1; pt[2] = 4'h7; pd[2] = 16'h2222; ps[2] = nextSeq;
    pv[1] = 1; pt[1] = 4'h8; pd[1] = 16'h1111; ps[1] = nextSeq;
    nextSeq = nextSeq + 1'b1;
    step("R7");
    check(lastWin == 1, "R7", "tie to lower index", 32'(lastWin), 32'd1);
    step("R7");

    // R5: random arrivals in shuffled order
    for (int c = 0; c < 3000; c++) begin
      int start;
      start = int'($urandom % N);
      for (int k = 0; k < N; k++) begin
        int idx;
        idx = (start + k) % N;
        if (!pv[idx] && ($urandom % 100) < 35)
          addReq(idx, TW'(($urandom % 15) + 1), DW'($urandom));
      end
      step("R5");
    end
    for (int c = 0; c < N + 1; c++) step("R5");

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule